// File: doc/BRIEF.md
# Prioritized CPU Interrupt Level Resolver

This block gathers every interrupt source that can reach a processor core and reduces them to one registered trap request. Level requests arrive from a 15-line external bus and from a software-interrupt register; either of that register's two timer-match bits raises level 14. A pending interrupt-vector flag takes precedence over every level. The remaining candidates are masked against the current processor interrupt level and the global enable. The block then picks the highest level left and emits its trap type.

A trap already in service is protected. Suppose the core sits at a nonzero trap level, the trap type on top of its trap stack belongs to the external-interrupt group, and that type ranks above the new candidate. The resolver then leaves its output unchanged for that cycle. The output pair is re-evaluated on every clock from the current inputs and its own previous value.

Top module: `irq_resolver`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls with no source active, `irq_req` is 0 and `irq_tt` is 0.
- R2: Level k (1..15) is pending when `ext_lvl[k]` or `soft_reg[k]` is 1. When level k wins, `irq_tt` becomes 0x040 + k.
- R3: `soft_reg[0]` (tick match) and `soft_reg[16]` (system-tick match) are not levels of their own. Either of them makes level 14 pending.
- R4: When `vec_pend` is 1, the next output is `irq_req`=1 and `irq_tt`=0x060. This holds regardless of levels, `cur_pil` and `int_en`.
- R5: With no vector pending, if no level above `cur_pil` is pending (always the case for `cur_pil`=15), the next output is `irq_req`=0 and `irq_tt`=0. A level equal to `cur_pil` does not qualify.
- R6: With no vector pending, `int_en`=1 and some level above `cur_pil` pending, the highest pending level wins. The next output is `irq_req`=1 with that level's trap type, unless R7 applies.
- R7: If, in addition to R6, `trap_lvl` is nonzero, `stack_tt[8:4]` equals 0x04 and `stack_tt` is numerically greater than the candidate trap type, the outputs keep their previous values.
- R8: With no vector pending and `int_en`=0, the next output is `irq_req`=0 and `irq_tt`=0.
- R9: The outputs are registered. An input change is visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 15 | External level requests, bit k is level k (bits 15..1) |
| soft_reg | input | 17 | Software-interrupt register; [15:1] levels, [0] tick match, [16] system-tick match |
| vec_pend | input | 1 | Interrupt-vector pending flag |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| stack_tt | input | 9 | Trap type on top of the trap stack |
| irq_req | output | 1 | Hard-interrupt request |
| irq_tt | output | 9 | Trap-type index of the request |

## Verification
The only state is the registered request and trap type. A wrong value shows up at the ports on the edge after the inputs that produced it. That error can persist indefinitely, though, because the R7 hold branch recirculates the old pair for as long as a higher external trap stays on the stack. The bench therefore checks every cycle against a model that carries its own copy of the previous output. It also drives long hold runs, so that a stale or corrupted held value is caught on the cycle it first differs.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
    localparam int NLVL     = 16;             // levels 0..15, level 0 unused
    localparam int LVLW     = $clog2(NLVL);
    localparam int TTW      = 9;
    localparam int TLW      = 3;
    localparam int TIMER_LVL = 14;
    localparam logic [TTW-1:0] EXT_BASE = 9'h040;
    localparam logic [TTW-1:0] VEC_TT   = 9'h060;

    typedef struct packed {
        logic           req;
        logic [TTW-1:0] tt;
    } irq_out_t;

    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_VEC   = 2'd1,
        ACT_GRANT = 2'd2,
        ACT_HOLD  = 2'd3
    } irq_act_e;

    function automatic logic [TTW-1:0] level_tt(input logic [LVLW-1:0] lvl);
        return EXT_BASE | {{(TTW-LVLW){1'b0}}, lvl};
    endfunction

    function automatic logic in_ext_group(input logic [TTW-1:0] tt);
        return tt[TTW-1:4] == EXT_BASE[TTW-1:4];
    endfunction
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge
    import irq_resolver_pkg::*;
#(
    parameter int LVLS = NLVL,
    parameter int TLV  = TIMER_LVL
) (
    input  logic [LVLS-1:1] ext_lvl,
    input  logic [LVLS:0]   soft_reg,
    output logic [LVLS-1:0] pend
);
    logic timer_hit;
    assign timer_hit = soft_reg[0] | soft_reg[LVLS];

    for (genvar i = 0; i < LVLS; i++) begin : g_lvl
        if (i == 0) begin : g_zero
            assign pend[i] = 1'b0;
        end else if (i == TLV) begin : g_timer
            assign pend[i] = ext_lvl[i] | soft_reg[i] | timer_hit;
        end else begin : g_plain
            assign pend[i] = ext_lvl[i] | soft_reg[i];
        end
    end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_resolver_pkg::*;
#(
    parameter int LVLS = NLVL,
    localparam int LW  = $clog2(LVLS)
) (
    input  logic [LVLS-1:0] pend,
    input  logic [LW-1:0]   cur_pil,
    output logic            found,
    output logic [LW-1:0]   win_lvl
);
    logic [LVLS-1:0] above;

    for (genvar i = 0; i < LVLS; i++) begin : g_mask
        assign above[i] = pend[i] && (i > int'(cur_pil));
    end

    always_comb begin
        found   = 1'b0;
        win_lvl = '0;
        for (int i = 0; i < LVLS; i++) begin
            if (above[i]) begin
                found   = 1'b1;
                win_lvl = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_resolver_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [15:1]     ext_lvl,
    input  logic [16:0]     soft_reg,
    input  logic            vec_pend,
    input  logic [3:0]      cur_pil,
    input  logic            int_en,
    input  logic [2:0]      trap_lvl,
    input  logic [8:0]      stack_tt,
    output logic            irq_req,
    output logic [8:0]      irq_tt
);
    logic [NLVL-1:0] pend;
    logic            found;
    logic [LVLW-1:0] win_lvl;
    logic [TTW-1:0]  cand_tt;
    logic            suppress;
    irq_act_e        act;
    irq_out_t        out_q, out_d;

    irq_pend_merge #(.LVLS(NLVL), .TLV(TIMER_LVL)) u_merge (
        .ext_lvl (ext_lvl),
        .soft_reg(soft_reg),
        .pend    (pend)
    );

    irq_level_pick #(.LVLS(NLVL)) u_pick (
        .pend   (pend),
        .cur_pil(cur_pil),
        .found  (found),
        .win_lvl(win_lvl)
    );

    assign cand_tt  = level_tt(win_lvl);
    assign suppress = (trap_lvl != '0) && in_ext_group(stack_tt) && (stack_tt > cand_tt);

    always_comb begin
        if (vec_pend)       act = ACT_VEC;
        else if (!found)    act = ACT_CLEAR;
        else if (!int_en)   act = ACT_CLEAR;
        else if (suppress)  act = ACT_HOLD;
        else                act = ACT_GRANT;
    end

    always_comb begin
        unique case (act)
            ACT_VEC:   out_d = '{req: 1'b1, tt: VEC_TT};
            ACT_GRANT: out_d = '{req: 1'b1, tt: cand_tt};
            ACT_HOLD:  out_d = out_q;
            default:   out_d = '{req: 1'b0, tt: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '{req: 1'b0, tt: '0};
        else     out_q <= out_d;
    end

    assign irq_req = out_q.req;
    assign irq_tt  = out_q.tt;

    // Assertions
    p_reset_r1: assert property (@(posedge clk) rst |=> (!irq_req && irq_tt == '0));
    p_vec_r4: assert property (@(posedge clk) disable iff (rst)
        vec_pend |=> (irq_req && irq_tt == VEC_TT));
    p_none_r5: assert property (@(posedge clk) disable iff (rst)
        (!vec_pend && !found) |=> (!irq_req && irq_tt == '0));
    p_win_r6: assert property (@(posedge clk) disable iff (rst)
        found |-> (pend[win_lvl] && win_lvl > cur_pil));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> ($stable(irq_req) && $stable(irq_tt)));
    p_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!vec_pend && !int_en) |=> (!irq_req && irq_tt == '0));
    p_timer_r3: assert property (@(posedge clk) disable iff (rst)
        (soft_reg[0] || soft_reg[16]) |-> pend[TIMER_LVL]);
    p_pair_r2: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_tt == VEC_TT || (in_ext_group(irq_tt) && irq_tt[3:0] != '0)));
endmodule

// File: tb/irq_resolver_tb.sv
`timescale 1ns/1ps
module irq_resolver_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:1] ext_lvl = '0;
    logic [16:0] soft_reg = '0;
    logic        vec_pend = 1'b0;
    logic [3:0]  cur_pil = '0;
    logic        int_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  stack_tt = '0;
    logic        irq_req;
    logic [8:0]  irq_tt;

    int checks = 0;
    int errors = 0;
    logic       exp_r = 1'b0;
    logic [8:0] exp_t = '0;

    always #5 clk = ~clk;

    irq_resolver u_dut (
        .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_reg(soft_reg),
        .vec_pend(vec_pend), .cur_pil(cur_pil), .int_en(int_en),
        .trap_lvl(trap_lvl), .stack_tt(stack_tt),
        .irq_req(irq_req), .irq_tt(irq_tt)
    );

    // Next-state model written from the requirements
    function automatic void model(output logic nr, output logic [8:0] nt, output string br);
        logic [15:0] p;
        int top;
        logic [8:0] cand;
        p = '0;
        for (int k = 1; k < 16; k++) p[k] = ext_lvl[k] | soft_reg[k];
        if (soft_reg[0] || soft_reg[16]) p[14] = 1'b1;
        top = 0;
        for (int k = 15; k > int'(cur_pil); k--) if (top == 0 && p[k]) top = k;
        cand = 9'h040 + 9'(top);
        if (vec_pend) begin nr = 1'b1; nt = 9'h060; br = "R4"; end
        else if (top == 0) begin nr = 1'b0; nt = '0; br = "R5"; end
        else if (!int_en) begin nr = 1'b0; nt = '0; br = "R8"; end
        else if (trap_lvl != 0 && stack_tt[8:4] == 5'h04 && stack_tt > cand) begin
            nr = exp_r; nt = exp_t; br = "R7";
        end else begin nr = 1'b1; nt = cand; br = "R6"; end
    endfunction

    task automatic check(string tag, logic ar, logic [8:0] at, logic er, logic [8:0] et);
        checks++;
        if (ar !== er || at !== et) begin
            errors++;
            $display("FAIL %s: req/tt actual %0b/%03h expected %0b/%03h", tag, ar, at, er, et);
        end
    endtask

    task automatic step(input logic [15:1] e, input logic [16:0] s, input logic v,
                        input logic [3:0] p, input logic ie, input logic [2:0] tl,
                        input logic [8:0] tt, input string tag);
        logic nr; logic [8:0] nt; string br;
        @(negedge clk);
        ext_lvl = e; soft_reg = s; vec_pend = v; cur_pil = p;
        int_en = ie; trap_lvl = tl; stack_tt = tt;
        #1;
        if (tag == "R9") check("R9", irq_req, irq_tt, exp_r, exp_t);
        model(nr, nt, br);
        @(posedge clk); #1;
        check(tag == "" ? br : tag, irq_req, irq_tt, nr, nt);
        exp_r = nr; exp_t = nt;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check("R1", irq_req, irq_tt, 1'b0, 9'h000);
        @(negedge clk); rst = 1'b0;
        step('0, '0, 0, 0, 1, 0, 0, "R1");

        // R2: external and software levels
        step(15'h0010, '0, 0, 2, 1, 0, 0, "R2");          // level 5 -> 045
        step('0, 17'h00200, 0, 2, 1, 0, 0, "R2");         // soft level 9 -> 049
        step(15'h0004, 17'h01000, 0, 2, 1, 0, 0, "R2");   // levels 3,12 -> 04C
        // R3: timer bits fold into 14
        step('0, 17'h00001, 0, 0, 1, 0, 0, "R3");
        step('0, 17'h10000, 0, 0, 1, 0, 0, "R3");
        step(15'h4000, 17'h00001, 0, 0, 1, 0, 0, "R3");   // level 15 still wins
        // R5: nothing above pil
        step(15'h0008, '0, 0, 4, 1, 0, 0, "R5");          // level 4 at pil 4
        step('1, '1, 0, 15, 1, 0, 0, "R5");
        // R4: vector beats everything
        step('1, '0, 1, 15, 0, 0, 0, "R4");
        step('0, '0, 1, 0, 1, 3, 9'h04F, "R4");
        // R8: disabled
        step(15'h0100, '0, 0, 0, 0, 0, 0, "R8");
        // R7: suppression
        step(15'h0004, '0, 0, 0, 1, 0, 0, "R6");           // grant 043
        step(15'h0010, '0, 0, 0, 1, 1, 9'h04A, "R7");      // hold 043
        step(15'h0010, '0, 0, 0, 1, 2, 9'h04B, "R7");
        step(15'h0010, '0, 0, 0, 1, 1, 9'h045, "R7");      // equal: grant 045
        step(15'h0040, '0, 0, 0, 1, 0, 9'h04F, "R7");      // tl 0: grant 047
        step(15'h0004, '0, 0, 0, 1, 1, 9'h14F, "R7");      // other group: grant 043
        // R9: registered output
        step(15'h2000, '0, 0, 0, 1, 0, 0, "R9");
        step('0, '0, 1, 0, 1, 0, 0, "R9");

        for (int n = 0; n < 3000; n++) begin
            logic [15:1] e; logic [16:0] s; logic [8:0] tt;
            e  = ($urandom % 3 == 0) ? 15'($urandom) : 15'(1 << ($urandom % 15));
            s  = ($urandom % 4 == 0) ? 17'($urandom) : '0;
            tt = ($urandom % 2 == 0) ? 9'(9'h040 | ($urandom % 16)) : 9'($urandom);
            step(e, s, ($urandom % 8) == 0, 4'($urandom), ($urandom % 4) != 0,
                 3'($urandom % 3), tt, "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule